// File: doc/BRIEF.md
# Resynchronising Packet UART Receiver

This block receives asynchronous serial characters on a multi-drop RS485 bus for a slave node. It takes the raw receive line and a strobe at sixteen times the bit rate. It resynchronises the line, finds each start edge, samples every bit at its centre and checks the stop bit. It delivers received bytes with a one-cycle valid strobe, a start-of-packet flag and, in 9-bit mode, the ninth bit, which marks an address byte.

A stop bit sampled low is a framing error. The block pulses an error strobe, which tells the consumer to discard every byte of the current packet. It then locks out reception. Until the line has stayed high without a break for one full character time, every character is dropped silently. This keeps a byte framed from the wrong edge from being taken as the start of a packet from the master.

Packet boundaries come from line idle time. If the line was high for a full character time before a byte, that byte opens a packet. In 9-bit mode, an address byte always opens a packet.

Top module: `uart_pkt_rx`

## Requirements
- R1: In 8-bit mode (`nine_bit_mode`=0) a frame is one low start bit, 8 data bits sent least significant first, and one high stop bit, each lasting 16 `os_tick` strobes. After a good frame, `rx_valid` pulses for exactly one clock cycle, with the data on `rx_data`.
- R2: In 9-bit mode (`nine_bit_mode`=1) a ninth data bit follows the eighth. It is reported on `rx_addr` together with `rx_valid`, and the stop bit follows it.
- R3: A low start level is accepted only if the line is still low at the eighth tick after the falling edge. A shorter low pulse produces neither `rx_valid` nor `rx_err`.
- R4: A stop bit sampled low makes `rx_err` pulse for one cycle instead of `rx_valid`, in both modes.
- R5: After `rx_err`, every character is discarded without `rx_valid` or `rx_err` until the line has been continuously high for one character time: 10 bit times in 8-bit mode, 11 in 9-bit mode.
- R6: Once that idle time has passed, reception resumes, and the next good byte has `rx_sop`=1.
- R7: `rx_sop` is 1 on the first byte after reset and on any byte preceded by at least one character time of continuous high line. Otherwise it is 0.
- R8: In 9-bit mode, a byte whose ninth bit is 1 has `rx_sop`=1 even when there was no idle gap before it.
- R9: While reset is asserted and after it is released, `rx_valid`, `rx_err`, `rx_sop`, `rx_addr` and `rx_data` are all 0.
- R10: In 8-bit mode, `rx_addr` is 0 with every valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| nine_bit_mode | input | 1 | 1 selects 9-bit addressed framing |
| rx_data | output | 8 | Received data byte |
| rx_addr | output | 1 | Ninth bit of the frame (address flag) |
| rx_valid | output | 1 | One-cycle strobe for a good byte |
| rx_sop | output | 1 | The byte opens a new packet |
| rx_err | output | 1 | One-cycle framing-error strobe: drop the packet |

## Verification
On every cycle the assertions check the following:
- The output strobes are single cycles and never occur together.
- `rx_addr` stays 0 in 8-bit mode.
- Address bytes are always marked as packet starts.
- No byte is delivered inside the lockout window. The checker measures this window from the resynchronised line independently of the design's own timer.

Only the bench scenarios can show the rest:
- Bit order and the values of the data.
- Rejection of a short start glitch.
- Detection of a bad stop bit in each mode.
- Silent dropping of good and bad characters during lockout.
- Start-of-packet marking after short and long gaps.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_e;

   // oversample ticks in one full character (start + data + optional ninth + stop)
   function automatic int char_ticks(input int data_w, input int osr, input bit ninth);
      return (data_w + 2 + (ninth ? 1 : 0)) * osr;
   endfunction

endpackage

// File: rtl/uart_pkt_sync.sv
module uart_pkt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= q[i-1];
         end
      end
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_pkt_framer.sv
module uart_pkt_framer
   import uart_pkt_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              nine_en,
   output logic              done,
   output logic              fail,
   output logic [DATA_W:0]   word
);
   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [BIT_W-1:0]  last_bit;
   logic [DATA_W:0]   shreg;
   logic              nine_lat;
   logic [DATA_W:0]   aligned;

   assign last_bit = nine_lat ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
   assign aligned  = nine_lat ? shreg : {1'b0, shreg[DATA_W:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         nine_lat <= 1'b0;
         done     <= 1'b0;
         fail     <= 1'b0;
         word     <= '0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (!line) begin
                     state    <= ST_START;
                     cnt      <= '0;
                     nine_lat <= nine_en;
                  end
               end
               ST_START: begin
                  if (cnt == MID) begin
                     cnt  <= '0;
                     bitn <= '0;
                     state <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shreg <= {line, shreg[DATA_W:1]};
                     bitn  <= bitn + 1'b1;
                     if (bitn == last_bit) state <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                     word  <= aligned;
                     if (line) done <= 1'b1;
                     else      fail <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_pkt_idle.sv
module uart_pkt_idle
   import uart_pkt_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic nine_en,
   output logic quiet
);
   localparam int MAXT = char_ticks(DATA_W, OSR, 1'b1);
   localparam int CW   = $clog2(MAXT + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = nine_en ? CW'(char_ticks(DATA_W, OSR, 1'b1))
                          : CW'(char_ticks(DATA_W, OSR, 1'b0));
   assign quiet = (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (tick) begin
         if (!line)          cnt <= '0;
         else if (!quiet)    cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/uart_pkt_rx.sv
module uart_pkt_rx #(
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ADDR_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_line,
   input  logic              nine_bit_mode,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_addr,
   output logic              rx_valid,
   output logic              rx_sop,
   output logic              rx_err
);
   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("uart_pkt_rx: OSR must be even and at least 4");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_pkt_rx: DATA_W must lie in 5..9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_pkt_rx: SYNC_STAGES must be at least 2");
   end

   logic            line_s;
   logic            nine_en;
   logic            f_done;
   logic            f_fail;
   logic [DATA_W:0] f_word;
   logic            quiet;
   logic            blocked;
   logic            gap;

   if (ADDR_EN) begin : g_addr
      assign nine_en = nine_bit_mode;
   end else begin : g_noaddr
      assign nine_en = nine_bit_mode & 1'b0;
   end

   uart_pkt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (line_s)
   );

   uart_pkt_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (os_tick),
      .line   (line_s),
      .nine_en(nine_en),
      .done   (f_done),
      .fail   (f_fail),
      .word   (f_word)
   );

   uart_pkt_idle #(.OSR(OSR), .DATA_W(DATA_W)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (os_tick),
      .line   (line_s),
      .nine_en(nine_en),
      .quiet  (quiet)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blocked  <= 1'b0;
         gap      <= 1'b1;
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
         rx_sop   <= 1'b0;
         rx_addr  <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
         rx_sop   <= 1'b0;
         if (quiet) begin
            blocked <= 1'b0;
            gap     <= 1'b1;
         end
         if (f_fail && !blocked) begin
            rx_err  <= 1'b1;
            blocked <= 1'b1;
         end
         if (f_done && !blocked) begin
            rx_valid <= 1'b1;
            rx_data  <= f_word[DATA_W-1:0];
            rx_addr  <= f_word[DATA_W];
            rx_sop   <= gap | f_word[DATA_W];
            gap      <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_pkt_rx_chk.sv
module uart_pkt_rx_chk
   import uart_pkt_pkg::*;
#(
   parameter int OSR     = 16,
   parameter int DATA_W  = 8,
   parameter bit ADDR_EN = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic os_tick,
   input logic line_s,
   input logic nine_bit_mode,
   input logic rx_valid,
   input logic rx_err,
   input logic rx_sop,
   input logic rx_addr
);
   localparam int CW = $clog2(char_ticks(DATA_W, OSR, 1'b1) + 1);

   logic          ninth;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] need;
   logic          lock;

   assign ninth = nine_bit_mode & ADDR_EN;
   assign need  = ninth ? CW'(char_ticks(DATA_W, OSR, 1'b1))
                        : CW'(char_ticks(DATA_W, OSR, 1'b0));

   // independent model of the lockout window
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         lock   <= 1'b0;
      end else begin
         if (os_tick) begin
            if (!line_s)            hi_cnt <= '0;
            else if (hi_cnt < need) hi_cnt <= hi_cnt + 1'b1;
         end
         if (rx_err)              lock <= 1'b1;
         else if (hi_cnt >= need) lock <= 1'b0;
      end
   end

   p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |=> !rx_err);

   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_err));

   p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !lock);

   p_addr_sop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && ninth && rx_addr) |-> rx_sop);

   p_no_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !nine_bit_mode) |-> !rx_addr);

   p_sop_only_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sop |-> rx_valid);
endmodule

bind uart_pkt_rx uart_pkt_rx_chk #(
   .OSR(OSR), .DATA_W(DATA_W), .ADDR_EN(ADDR_EN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .os_tick      (os_tick),
   .line_s       (line_s),
   .nine_bit_mode(nine_bit_mode),
   .rx_valid     (rx_valid),
   .rx_err       (rx_err),
   .rx_sop       (rx_sop),
   .rx_addr      (rx_addr)
);

// File: tb/tb_uart_pkt_rx.sv
module tb_uart_pkt_rx;
   localparam int OSR = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic [7:0] rx_data;
   logic       rx_addr, rx_valid, rx_sop, rx_err;

   int checks = 0;
   int bad    = 0;
   bit done_flag = 1'b0;

   typedef struct packed {
      logic       is_err;
      logic [7:0] data;
      logic       addr;
      logic       sop;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   uart_pkt_rx dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
      .nine_bit_mode(nine_bit_mode), .rx_data(rx_data), .rx_addr(rx_addr),
      .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_err(rx_err)
   );

   always #10 clk = ~clk;

   always @(negedge clk) os_tick <= ~os_tick;

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!os_tick) @(posedge clk);
      end
   endtask

   task automatic drive(input logic v, input int n);
      @(negedge clk);
      rx_line = v;
      wait_ticks(n);
   endtask

   task automatic expect_byte(input logic [7:0] d, input logic a, input logic s, input string tag);
      exp_q.push_back('{is_err: 1'b0, data: d, addr: a, sop: s});
      tag_q.push_back(tag);
   endtask

   task automatic expect_err(input string tag);
      exp_q.push_back('{is_err: 1'b1, data: 8'h00, addr: 1'b0, sop: 1'b0});
      tag_q.push_back(tag);
   endtask

   // send one character; nine selects 9-bit framing
   task automatic send(input logic [8:0] w, input bit nine, input bit good_stop);
      drive(1'b0, OSR);
      for (int i = 0; i < (nine ? 9 : 8); i++) drive(w[i], OSR);
      drive(good_stop, OSR);
      @(negedge clk);
      rx_line = 1'b1;
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (rx_valid || rx_err)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3/R5", "unexpected output", {rx_err, rx_valid, 14'h0}, 16'h0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.is_err) begin
               check(rx_err && !rx_valid, t, "error strobe", {14'h0, rx_err, rx_valid}, 16'h2);
            end else begin
               check(rx_valid && !rx_err && rx_data == e.data && rx_addr == e.addr && rx_sop == e.sop,
                     t, "byte {valid,addr,sop,data}",
                     {5'h0, rx_valid, rx_addr, rx_sop, rx_data},
                     {5'h0, 1'b1, e.addr, e.sop, e.data});
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         bad++;
         $display("FAIL watchdog (all) actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(rx_valid == 0 && rx_err == 0 && rx_sop == 0 && rx_addr == 0 && rx_data == 0,
            "R9", "outputs in reset", {rx_valid, rx_err, rx_sop, rx_addr, 4'h0, rx_data}, 16'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(rx_valid == 0 && rx_err == 0 && rx_sop == 0 && rx_data == 0,
            "R9", "outputs after reset", {rx_valid, rx_err, rx_sop, rx_addr, 4'h0, rx_data}, 16'h0);

      // R1 / R7: 8-bit frames, first after reset opens packet, short gaps do not
      wait_ticks(40);
      expect_byte(8'hA5, 1'b0, 1'b1, "R1_R7");
      send(9'h0A5, 1'b0, 1'b1);
      wait_ticks(16);
      expect_byte(8'h3C, 1'b0, 1'b0, "R1_R7");
      send(9'h03C, 1'b0, 1'b1);
      wait_ticks(16);
      expect_byte(8'h00, 1'b0, 1'b0, "R1");
      send(9'h000, 1'b0, 1'b1);
      wait_ticks(8);
      expect_byte(8'hFF, 1'b0, 1'b0, "R1");
      send(9'h0FF, 1'b0, 1'b1);
      wait_ticks(200);
      expect_byte(8'h81, 1'b0, 1'b1, "R7");
      send(9'h081, 1'b0, 1'b1);

      // R3: short start glitch ignored
      wait_ticks(200);
      drive(1'b0, 4);
      drive(1'b1, 200);
      expect_byte(8'h5A, 1'b0, 1'b1, "R3");
      send(9'h05A, 1'b0, 1'b1);

      // R4 / R5 / R6: framing error, lockout, resume
      wait_ticks(16);
      expect_err("R4");
      send(9'h077, 1'b0, 1'b0);
      wait_ticks(16);
      send(9'h011, 1'b0, 1'b1);   // dropped (R5)
      wait_ticks(16);
      send(9'h022, 1'b0, 1'b0);   // dropped, no error (R5)
      wait_ticks(60);
      send(9'h033, 1'b0, 1'b1);   // gap too short, dropped (R5)
      wait_ticks(200);
      expect_byte(8'h44, 1'b0, 1'b1, "R6");
      send(9'h044, 1'b0, 1'b1);
      wait_ticks(16);
      expect_byte(8'h45, 1'b0, 1'b0, "R6");
      send(9'h045, 1'b0, 1'b1);

      // R2 / R8: 9-bit framing
      wait_ticks(40);
      nine_bit_mode = 1'b1;
      wait_ticks(200);
      expect_byte(8'h12, 1'b0, 1'b1, "R2");
      send(9'h012, 1'b1, 1'b1);
      wait_ticks(16);
      expect_byte(8'h34, 1'b1, 1'b1, "R8");
      send(9'h134, 1'b1, 1'b1);
      wait_ticks(16);
      expect_byte(8'h56, 1'b0, 1'b0, "R2");
      send(9'h056, 1'b1, 1'b1);
      wait_ticks(16);
      expect_err("R4");
      send(9'h09A, 1'b1, 1'b0);
      wait_ticks(60);
      send(9'h1BC, 1'b1, 1'b1);   // address byte during lockout dropped (R5)
      wait_ticks(220);
      expect_byte(8'hF0, 1'b1, 1'b1, "R6");
      send(9'h1F0, 1'b1, 1'b1);

      // R10: back to 8-bit, ninth bit absent
      wait_ticks(40);
      nine_bit_mode = 1'b0;
      wait_ticks(200);
      expect_byte(8'hC3, 1'b0, 1'b1, "R10");
      send(9'h0C3, 1'b0, 1'b1);

      wait_ticks(100);
      check(exp_q.size() == 0, "R1_R5", "pending expected items",
            16'(exp_q.size()), 16'h0);
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule